// File: doc/BRIEF.md
# CPU Slot Hotplug Event Controller

This block is the register front end through which a host processor learns about CPUs that are plugged into or unplugged from a fixed set of slots, and acknowledges those events. The environment signals a hot-add or hot-remove for a slot on side inputs. For each slot the block keeps an enabled flag, an insert-pending flag and a remove-pending flag. An interrupt request stays high while any slot has an event waiting.

Software reaches the block through a 12-byte register window, using byte and dword accesses in little-endian order. A 32-bit selector names the slot that the status, control and data registers act on. A command register chooses one of three uses for the data register. It can search for the next slot with pending events and load that slot into the selector. It can load a 32-bit OST event word. It can load a 32-bit OST status word, which also sends the two words out with a one-cycle notification pulse.

Accesses arrive on a valid/ready request channel. `acc_ready` is low only while a search is running, and a request that is held stays stable until it is accepted. A read is answered one cycle after acceptance on `rd_valid`/`rd_data`. The response has no back-pressure.

Top module: `cpu_slot_hp_ctrl`

## Requirements
- R1: A dword write at offset 0x0 loads the selector. A dword read at 0x8 returns the selector while the stored command is 0. A dword read at 0x0 always returns 0.
- R2: A byte read at 0x4 returns the status of the selected slot: bit 0 enabled, bit 1 insert pending, bit 2 remove pending, bits 7..3 zero.
- R3: A byte write at 0x4 acts on the selected slot. Bit 1 clears insert pending, bit 2 clears remove pending and bit 3 clears enabled (eject). Bits 0 and 7..4 have no effect.
- R4: A pulse on `hot_add[i]` sets the enabled and insert-pending flags of slot i. A pulse on `hot_rm[i]` sets its remove-pending flag. A set in the same cycle as a clear wins.
- R5: `irq` is high exactly when some slot has insert or remove pending.
- R6: A byte write of 0 at 0x5 starts a search. The search checks slots in ascending order from selector+1, wraps to 0, and checks the current selector last. It loads the first slot with an event into the selector within NUM_CPUS cycles. `acc_ready` is low while the search runs.
- R7: A search that finds no pending slot leaves the selector and all flags unchanged.
- R8: After command 1, dword writes at 0x8 load the OST event word. After command 2, they load the OST status word. A dword read at 0x8 returns 0 while the command is not 0.
- R9: A write of the OST status word gives a one-cycle `ost_pulse`. During that pulse, `ost_event` and `ost_status` carry the current event word and the new status word.
- R10: While the selector is NUM_CPUS or larger, every read returns 0 and every write other than a selector write is ignored. This includes command writes and control writes.
- R11: Any offset or access size other than those above reads 0, and writes to it are ignored.
- R12: `por_n` sets the selector to 0. `rst_n` clears the flags, the command and the OST words, and keeps the selector.
- R13: A request is accepted on a cycle with `acc_valid` and `acc_ready` both high. A read raises `rd_valid` with its data in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on reset, active low, initialises the selector |
| rst_n | input | 1 | Functional reset, active low, leaves the selector alone |
| acc_valid | input | 1 | Register access request valid |
| acc_ready | output | 1 | Request can be accepted (low during a search) |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_addr | input | 4 | Byte offset in the window |
| acc_dword | input | 1 | 1 = dword access, 0 = byte access |
| acc_wdata | input | 32 | Write data, little-endian, byte data in bits 7..0 |
| rd_valid | output | 1 | Read response valid, one cycle after acceptance |
| rd_data | output | 32 | Read response data |
| hot_add | input | NUM_CPUS | Per-slot hot-add pulse |
| hot_rm | input | NUM_CPUS | Per-slot hot-remove pulse |
| irq | output | 1 | Event pending interrupt request |
| ost_pulse | output | 1 | One-cycle pulse after an OST status write |
| ost_event | output | 32 | Current OST event word |
| ost_status | output | 32 | Current OST status word |

## Verification
The assertions take for granted that the request fields stay stable while `acc_valid` waits for `acc_ready`, and that the side inputs are one-cycle pulses synchronous to `clk`. They also take both resets as asserted together at time zero. The bench drives requests on the falling edge and holds them until an accepting rising edge. It pulses `hot_add`/`hot_rm` for exactly one cycle and releases both resets together before the first access. Once started, it pulses `rst_n` only on its own, so the selector-retention case stays within what the properties expect.

// File: rtl/cpu_slot_hp_pkg.sv
package cpu_slot_hp_pkg;
  typedef enum logic [7:0] {
    CMD_SCAN    = 8'd0,
    CMD_OST_EVT = 8'd1,
    CMD_OST_STS = 8'd2
  } hp_cmd_e;

  localparam logic [3:0] OFS_SEL  = 4'h0;
  localparam logic [3:0] OFS_STAT = 4'h4;
  localparam logic [3:0] OFS_CMD  = 4'h5;
  localparam logic [3:0] OFS_DATA = 4'h8;

  localparam int BIT_CLR_INS = 1;
  localparam int BIT_CLR_REM = 2;
  localparam int BIT_EJECT   = 3;
endpackage

// File: rtl/cpu_slot_hp_flags.sv
module cpu_slot_hp_flags
  import cpu_slot_hp_pkg::*;
#(
  parameter int NUM_CPUS = 8,
  localparam int IDX_W = (NUM_CPUS > 1) ? $clog2(NUM_CPUS) : 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_CPUS-1:0] hot_add,
  input  logic [NUM_CPUS-1:0] hot_rm,
  input  logic                ctl_we,
  input  logic [IDX_W-1:0]    ctl_idx,
  input  logic [7:0]          ctl_bits,
  output logic [NUM_CPUS-1:0] en,
  output logic [NUM_CPUS-1:0] ins,
  output logic [NUM_CPUS-1:0] rem
);
  for (genvar i = 0; i < NUM_CPUS; i++) begin : g_slot
    logic hit;
    assign hit = ctl_we && (ctl_idx == IDX_W'(i));

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        en[i]  <= 1'b0;
        ins[i] <= 1'b0;
        rem[i] <= 1'b0;
      end else begin
        if (hit && ctl_bits[BIT_CLR_INS]) ins[i] <= 1'b0;
        if (hit && ctl_bits[BIT_CLR_REM]) rem[i] <= 1'b0;
        if (hit && ctl_bits[BIT_EJECT])   en[i]  <= 1'b0;
        // environment events win over a same-cycle clear
        if (hot_add[i]) begin
          en[i]  <= 1'b1;
          ins[i] <= 1'b1;
        end
        if (hot_rm[i]) rem[i] <= 1'b1;
      end
    end

    p_set_wins_r4: assert property (@(posedge clk) disable iff (!rst_n)
      hot_add[i] |=> (en[i] && ins[i]));
    p_rm_sets_r4: assert property (@(posedge clk) disable iff (!rst_n)
      hot_rm[i] |=> rem[i]);
    p_eject_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (hit && ctl_bits[BIT_EJECT] && !hot_add[i]) |=> !en[i]);
  end
endmodule

// File: rtl/cpu_slot_hp_scan.sv
module cpu_slot_hp_scan #(
  parameter int NUM_CPUS = 8,
  localparam int IDX_W = (NUM_CPUS > 1) ? $clog2(NUM_CPUS) : 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start,
  input  logic [IDX_W-1:0]    from_idx,
  input  logic [NUM_CPUS-1:0] pend,
  output logic                busy,
  output logic                done,
  output logic                found,
  output logic [IDX_W-1:0]    result
);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(NUM_CPUS - 1);

  logic [IDX_W-1:0] cand_q, cnt_q;

  function automatic logic [IDX_W-1:0] next_idx(input logic [IDX_W-1:0] v);
    return (v == LAST) ? '0 : v + 1'b1;
  endfunction

  assign found  = busy && pend[cand_q];
  assign done   = busy && (found || cnt_q == LAST);
  assign result = cand_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy   <= 1'b0;
      cand_q <= '0;
      cnt_q  <= '0;
    end else if (start && !busy) begin
      busy   <= 1'b1;
      cand_q <= next_idx(from_idx);
      cnt_q  <= '0;
    end else if (busy) begin
      if (done) begin
        busy <= 1'b0;
      end else begin
        cand_q <= next_idx(cand_q);
        cnt_q  <= cnt_q + 1'b1;
      end
    end
  end

  p_scan_bounded_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && cnt_q == LAST) |=> !busy);
endmodule

// File: rtl/cpu_slot_hp_ctrl.sv
module cpu_slot_hp_ctrl
  import cpu_slot_hp_pkg::*;
#(
  parameter int NUM_CPUS = 8,
  localparam int IDX_W = (NUM_CPUS > 1) ? $clog2(NUM_CPUS) : 1
) (
  input  logic                clk,
  input  logic                por_n,
  input  logic                rst_n,
  input  logic                acc_valid,
  output logic                acc_ready,
  input  logic                acc_write,
  input  logic [3:0]          acc_addr,
  input  logic                acc_dword,
  input  logic [31:0]         acc_wdata,
  output logic                rd_valid,
  output logic [31:0]         rd_data,
  input  logic [NUM_CPUS-1:0] hot_add,
  input  logic [NUM_CPUS-1:0] hot_rm,
  output logic                irq,
  output logic                ost_pulse,
  output logic [31:0]         ost_event,
  output logic [31:0]         ost_status
);
  logic [31:0]         sel_q;
  logic [7:0]          cmd_q;
  logic [NUM_CPUS-1:0] en, ins, rem;
  logic                scan_busy, scan_done, scan_found;
  logic [IDX_W-1:0]    scan_res;
  logic                fire, wr, rd, sel_ok;
  logic                is_sel, is_stat, is_cmd, is_data;
  logic                scan_start;
  logic [31:0]         rd_mux;
  logic [IDX_W-1:0]    sel_idx;

  assign acc_ready = !scan_busy;
  assign fire      = acc_valid && acc_ready;
  assign wr        = fire && acc_write;
  assign rd        = fire && !acc_write;
  assign sel_ok    = (sel_q < 32'(NUM_CPUS));
  assign sel_idx   = sel_q[IDX_W-1:0];

  assign is_sel  = (acc_addr == OFS_SEL)  &&  acc_dword;
  assign is_stat = (acc_addr == OFS_STAT) && !acc_dword;
  assign is_cmd  = (acc_addr == OFS_CMD)  && !acc_dword;
  assign is_data = (acc_addr == OFS_DATA) &&  acc_dword;

  assign scan_start = wr && is_cmd && sel_ok && (acc_wdata[7:0] == CMD_SCAN);
  assign irq        = |(ins | rem);

  cpu_slot_hp_flags #(.NUM_CPUS(NUM_CPUS)) u_flags (
    .clk      (clk),
    .rst_n    (rst_n),
    .hot_add  (hot_add),
    .hot_rm   (hot_rm),
    .ctl_we   (wr && is_stat && sel_ok),
    .ctl_idx  (sel_idx),
    .ctl_bits (acc_wdata[7:0]),
    .en       (en),
    .ins      (ins),
    .rem      (rem)
  );

  cpu_slot_hp_scan #(.NUM_CPUS(NUM_CPUS)) u_scan (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (scan_start),
    .from_idx (sel_idx),
    .pend     (ins | rem),
    .busy     (scan_busy),
    .done     (scan_done),
    .found    (scan_found),
    .result   (scan_res)
  );

  // selector: power-on only, survives functional reset
  always_ff @(posedge clk) begin
    if (!por_n)                 sel_q <= '0;
    else if (wr && is_sel)      sel_q <= acc_wdata;
    else if (rst_n && scan_done && scan_found) sel_q <= 32'(scan_res);
  end

  always_comb begin
    rd_mux = '0;
    if (sel_ok) begin
      if (is_stat)                        rd_mux = {29'd0, rem[sel_idx], ins[sel_idx], en[sel_idx]};
      else if (is_data && cmd_q == CMD_SCAN) rd_mux = sel_q;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmd_q      <= CMD_SCAN;
      ost_event  <= '0;
      ost_status <= '0;
      ost_pulse  <= 1'b0;
      rd_valid   <= 1'b0;
      rd_data    <= '0;
    end else begin
      ost_pulse <= 1'b0;
      rd_valid  <= rd;
      if (rd) rd_data <= rd_mux;
      if (wr && sel_ok && is_cmd) cmd_q <= acc_wdata[7:0];
      if (wr && sel_ok && is_data) begin
        if (cmd_q == CMD_OST_EVT) ost_event <= acc_wdata;
        if (cmd_q == CMD_OST_STS) begin
          ost_status <= acc_wdata;
          ost_pulse  <= 1'b1;
        end
      end
    end
  end

  p_busy_blocks_r6: assert property (@(posedge clk) disable iff (!rst_n || !por_n)
    scan_start |=> !acc_ready);
  p_sel_kept_r7: assert property (@(posedge clk) disable iff (!rst_n || !por_n)
    (scan_done && !scan_found) |=> $stable(sel_q));
  p_rsp_next_r13: assert property (@(posedge clk) disable iff (!rst_n || !por_n)
    rd |=> rd_valid);
  p_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n || !por_n)
    (rd && !sel_ok) |=> (rd_data == 32'd0));
  p_pulse_src_r9: assert property (@(posedge clk) disable iff (!rst_n || !por_n)
    ost_pulse |-> $past(wr && is_data && sel_ok && cmd_q == CMD_OST_STS));
endmodule

// File: tb/cpu_slot_hp_ctrl_bench.sv
module cpu_slot_hp_ctrl_bench;
  localparam int N = 8;

  logic        clk = 1'b0;
  logic        por_n = 1'b0, rst_n = 1'b0;
  logic        acc_valid = 1'b0, acc_write = 1'b0, acc_dword = 1'b0;
  logic [3:0]  acc_addr = '0;
  logic [31:0] acc_wdata = '0;
  logic        acc_ready, rd_valid, irq, ost_pulse;
  logic [31:0] rd_data, ost_event, ost_status;
  logic [N-1:0] hot_add = '0, hot_rm = '0;

  int checks = 0, errors = 0, pulses = 0, cycles = 0;
  logic [31:0] r;

  always #10 clk = ~clk;

  cpu_slot_hp_ctrl #(.NUM_CPUS(N)) u_cpu_slot_hp_ctrl (
    .clk(clk), .por_n(por_n), .rst_n(rst_n),
    .acc_valid(acc_valid), .acc_ready(acc_ready), .acc_write(acc_write),
    .acc_addr(acc_addr), .acc_dword(acc_dword), .acc_wdata(acc_wdata),
    .rd_valid(rd_valid), .rd_data(rd_data),
    .hot_add(hot_add), .hot_rm(hot_rm), .irq(irq),
    .ost_pulse(ost_pulse), .ost_event(ost_event), .ost_status(ost_status)
  );

  always @(negedge clk) if (ost_pulse) pulses++;

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      errors++;
      $display("FAIL watchdog: act=%0d cycles exp=<100000", cycles);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: act=0x%0h exp=0x%0h", req, act, exp);
    end
  endtask

  task automatic access(input logic w, input logic [3:0] a, input logic dw,
                        input logic [31:0] d, output logic [31:0] q);
    @(negedge clk);
    acc_valid = 1'b1; acc_write = w; acc_addr = a; acc_dword = dw; acc_wdata = d;
    while (!acc_ready) @(negedge clk);
    @(posedge clk);
    @(negedge clk);
    acc_valid = 1'b0;
    q = rd_data;
    if (!w && !rd_valid) begin
      errors++;
      $display("FAIL R13: act rd_valid=0 exp=1");
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic dw, input logic [31:0] d);
    logic [31:0] q;
    access(1'b1, a, dw, d, q);
  endtask

  task automatic rd(input logic [3:0] a, input logic dw, output logic [31:0] q);
    access(1'b0, a, dw, 32'd0, q);
  endtask

  task automatic add(input int k);
    @(negedge clk); hot_add[k] = 1'b1;
    @(negedge clk); hot_add = '0;
  endtask

  task automatic rmv(input int k);
    @(negedge clk); hot_rm[k] = 1'b1;
    @(negedge clk); hot_rm = '0;
  endtask

  typedef struct packed {
    logic        w;
    logic [3:0]  a;
    logic        dw;
    logic [31:0] d;
    logic [31:0] e;
  } vec_t;

  localparam int NV = 10;
  localparam vec_t TBL [NV] = '{
    '{1'b0, 4'h4, 1'b0, 32'd0, 32'd0},  // R2 slot 0 idle
    '{1'b0, 4'h8, 1'b1, 32'd0, 32'd0},  // R1 selector 0
    '{1'b1, 4'h0, 1'b1, 32'd3, 32'd0},  // R1 select 3
    '{1'b0, 4'h8, 1'b1, 32'd0, 32'd3},  // R1 readback
    '{1'b1, 4'h5, 1'b0, 32'd1, 32'd0},  // R8 cmd 1
    '{1'b0, 4'h8, 1'b1, 32'd0, 32'd0},  // R8 data reads 0
    '{1'b1, 4'h5, 1'b0, 32'd0, 32'd0},  // R7 search, nothing pending
    '{1'b0, 4'h8, 1'b1, 32'd0, 32'd3},  // R7 selector kept
    '{1'b0, 4'h0, 1'b1, 32'd0, 32'd0},  // R1 offset 0 reads 0
    '{1'b0, 4'h6, 1'b0, 32'd0, 32'd0}   // R11 reserved offset
  };

  initial begin
    repeat (3) @(negedge clk);
    por_n = 1'b1; rst_n = 1'b1;
    @(negedge clk);
    chk("R12 reset irq", {31'd0, irq}, 32'd0);
    chk("R13 reset ready", {31'd0, acc_ready}, 32'd1);
    chk("R12 reset pulse", {31'd0, ost_pulse}, 32'd0);

    for (int i = 0; i < NV; i++) begin
      access(TBL[i].w, TBL[i].a, TBL[i].dw, TBL[i].d, r);
      if (!TBL[i].w) chk($sformatf("table row %0d", i), r, TBL[i].e);
    end

    // R4 / R5 / R2: insert and remove events on slot 5
    add(5);
    chk("R5 irq after add", {31'd0, irq}, 32'd1);
    wr(4'h0, 1'b1, 32'd5);
    rd(4'h4, 1'b0, r); chk("R4 add sets en+ins", r, 32'h3);
    rmv(5);
    rd(4'h4, 1'b0, r); chk("R2 all status bits", r, 32'h7);
    // R3 clears
    wr(4'h4, 1'b0, 32'h02);
    rd(4'h4, 1'b0, r); chk("R3 clear insert", r, 32'h5);
    wr(4'h4, 1'b0, 32'h04);
    rd(4'h4, 1'b0, r); chk("R3 clear remove", r, 32'h1);
    chk("R5 irq low", {31'd0, irq}, 32'd0);
    wr(4'h4, 1'b0, 32'hF1);
    rd(4'h4, 1'b0, r); chk("R3 ignored bits", r, 32'h1);
    wr(4'h4, 1'b0, 32'h08);
    rd(4'h4, 1'b0, r); chk("R3 eject", r, 32'h0);
    // R11 byte write to a dword register ignored
    wr(4'h0, 1'b0, 32'h7);
    rd(4'h8, 1'b1, r); chk("R11 byte write at 0 ignored", r, 32'd5);

    // R6 round-robin search
    add(2); add(6);
    wr(4'h5, 1'b0, 32'd0);
    chk("R6 busy holds ready", {31'd0, acc_ready}, 32'd0);
    rd(4'h8, 1'b1, r); chk("R6 first after 5", r, 32'd6);
    wr(4'h4, 1'b0, 32'h02);
    wr(4'h5, 1'b0, 32'd0);
    rd(4'h8, 1'b1, r); chk("R6 wrap to 2", r, 32'd2);
    wr(4'h4, 1'b0, 32'h02);
    wr(4'h5, 1'b0, 32'd0);
    rd(4'h8, 1'b1, r); chk("R7 no event keeps sel", r, 32'd2);
    rd(4'h4, 1'b0, r); chk("R7 flags untouched", r, 32'h1);

    // R10 invalid selector
    add(0);
    wr(4'h0, 1'b1, N);
    rd(4'h8, 1'b1, r); chk("R10 data reads 0", r, 32'd0);
    rd(4'h4, 1'b0, r); chk("R10 status reads 0", r, 32'd0);
    wr(4'h4, 1'b0, 32'h02);
    wr(4'h5, 1'b0, 32'd1);
    wr(4'h0, 1'b1, 32'd0);
    rd(4'h4, 1'b0, r); chk("R10 control ignored", r, 32'h3);
    rd(4'h8, 1'b1, r); chk("R10 command ignored", r, 32'd0);

    // R8 / R9 OST words
    wr(4'h5, 1'b0, 32'd1);
    wr(4'h8, 1'b1, 32'h0000_00AB);
    chk("R8 event loaded", ost_event, 32'hAB);
    chk("R9 no pulse on event", pulses, 0);
    wr(4'h5, 1'b0, 32'd2);
    wr(4'h8, 1'b1, 32'h0000_1234);
    chk("R9 pulse", {31'd0, ost_pulse}, 32'd1);
    chk("R9 status word", ost_status, 32'h1234);
    chk("R9 event word", ost_event, 32'hAB);
    @(negedge clk);
    chk("R9 single pulse", pulses, 1);

    // R12 selector survives functional reset
    wr(4'h0, 1'b1, 32'd4);
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    chk("R12 flags cleared", {31'd0, irq}, 32'd0);
    rd(4'h8, 1'b1, r); chk("R12 selector kept", r, 32'd4);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule